// File: doc/BRIEF.md
# USB OUT Endpoint Receive DMA Channel

This block is one DMA channel that empties a USB OUT endpoint into system memory. The endpoint hands over received bytes one at a time, with flags marking the last byte of a packet, whether that packet was short, and a separate beat for a zero-length packet. The channel writes each byte to memory through a simple byte-wide write port, starting at a programmed address and stepping the address by one per byte. The endpoint must be run in auto-validate mode while this channel is in use, so that a bank is released as soon as the channel has emptied it.

Software programs a destination address and a byte length, then writes the control register with the run bit set. A counter of bytes left in the buffer falls by one per byte moved. The transfer ends in one of two ways: the buffer fills up, or, when the short-packet option is set, a short or zero-length packet arrives. When the buffer fills in the middle of a packet, the rest of that packet either stays in the endpoint or, with truncation enabled, is drained and thrown away. Each end condition raises its own sticky flag and, if enabled, its own interrupt. The run bit clears itself when the channel finishes. Reading the status register returns the flags and clears them.

Register map (2-bit offset, 32-bit data): offset 0 is the buffer address, offset 1 is the buffer length, offset 2 is control, and offset 3 is status (read-only).

Top module: `rxdma_out_channel`

## Requirements
- R1: After reset the channel is idle. memWrEn, epReady, irqBufEnd and irqXferEnd are low, and a status read returns 0.
- R2: A control write with bit 0 (run) set, made while idle, latches the programmed address and length. The k-th byte accepted from the endpoint (k from 0) is written with memAddr = start + k and memWrData equal to that byte.
- R3: Status bits [31:16] hold the bytes left in the buffer. The count starts at the programmed length and falls by one for each byte accepted.
- R4: When the count reaches zero, the channel stops. Status bit 0 (active) and control bit 0 read 0, and status bit 1 (buffer-end flag) is set. With control bit 1 (truncate) clear, the rest of the packet is left in the endpoint and epReady stays low.
- R5: With control bit 1 (truncate) set, the bytes of the packet that overflow the buffer are accepted up to and including the byte with epLast, and none of them is written to memory.
- R6: With control bit 2 (end on short packet) set, accepting the last byte of a short packet (epLast and epShort) ends the transfer. Status bit 2 (transfer-end flag) is set and the count keeps the unused length. With bit 2 clear, a short packet does not stop the channel.
- R7: A beat with epZlp set writes nothing. With control bit 2 set it ends the transfer and sets the transfer-end flag. With bit 2 clear it is consumed and the channel keeps running with the same count.
- R8: irqBufEnd is high while the buffer-end flag and control bit 3 are both set. irqXferEnd is high while the transfer-end flag and control bit 4 are both set. A flag is set only once the final memory write has been accepted.
- R9: A status read returns the current flags and clears both of them, which also drops the interrupts. A flag that is set in the same cycle as the read stays set.
- R10: While memWrEn is high and memReady is low, memAddr and memWrData hold their values, and epReady is low unless the channel is discarding.
- R11: A control write with bit 0 clear stops an active channel at once. No flag is set and the count keeps its value.
- R12: Starting with a length of 0 ends the channel at once. It sets the buffer-end flag and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; regRdData is valid the next cycle |
| regAddr | input | 2 | Register offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data |
| epValid | input | 1 | Endpoint offers a beat |
| epReady | output | 1 | Channel takes the beat this cycle |
| epData | input | 8 | Received byte |
| epLast | input | 1 | Beat is the last byte of its packet |
| epShort | input | 1 | Packet is short (qualified by epLast) |
| epZlp | input | 1 | Beat stands for a zero-length packet and carries no data |
| memWrEn | output | 1 | Memory write request |
| memReady | input | 1 | Memory accepts the write this cycle |
| memAddr | output | ADDR_W | Byte address of the write |
| memWrData | output | 8 | Byte to write |
| irqBufEnd | output | 1 | Buffer-end interrupt |
| irqXferEnd | output | 1 | Transfer-end interrupt |

## Verification
The hardest case to reach is the buffer filling in the middle of a packet. What happens next depends on the truncate bit: the channel either refuses the rest of the packet or keeps accepting beats without writing them. The bench programs buffers shorter than the packets it sends and watches epReady and the write count while the extra bytes are offered. A second hard case is a stalled memory write with a new byte waiting behind it. The bench holds memReady low after one byte, offers the next byte, and checks that both the write and the handshake stay frozen until the memory is released.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  localparam int REG_W = 32;

  // register offsets
  localparam logic [1:0] OFS_ADDR = 2'd0;
  localparam logic [1:0] OFS_LEN  = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

  // control bits
  localparam int CB_RUN    = 0;
  localparam int CB_TRUNC  = 1;
  localparam int CB_SHORT  = 2;
  localparam int CB_BUFIRQ = 3;
  localparam int CB_XFRIRQ = 4;

  // status bits
  localparam int SB_ACTIVE  = 0;
  localparam int SB_BUFEND  = 1;
  localparam int SB_XFREND  = 2;
  localparam int SB_CNT_LSB = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DISCARD,
    ST_DRAIN
  } chState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // latch start address and length
    logic push;   // capture one byte into the write register
  } dpStrobe_t;

endpackage

// File: rtl/rxdma_datapath.sv
module rxdma_datapath
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  startLen,
  input  logic [7:0]        byteIn,
  input  logic              memReady,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic [LEN_W-1:0]  remaining,
  output logic              outBusy,
  output logic              canLoad
);

  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);
  localparam logic [LEN_W-1:0]  CNT_STEP  = LEN_W'(1);

  logic [ADDR_W-1:0] curAddrQ;
  logic [LEN_W-1:0]  remainQ;
  logic              outValidQ;
  logic [ADDR_W-1:0] outAddrQ;
  logic [7:0]        outDataQ;

  assign canLoad = !outValidQ || memReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddrQ <= '0;
      remainQ  <= '0;
    end else if (strobe.load) begin
      curAddrQ <= startAddr;
      remainQ  <= startLen;
    end else if (strobe.push) begin
      curAddrQ <= curAddrQ + ADDR_STEP;
      remainQ  <= remainQ - CNT_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
      outAddrQ  <= '0;
      outDataQ  <= '0;
    end else if (strobe.push) begin
      outValidQ <= 1'b1;
      outAddrQ  <= curAddrQ;
      outDataQ  <= byteIn;
    end else if (memReady) begin
      outValidQ <= 1'b0;
    end
  end

  assign memWrEn   = outValidQ;
  assign memAddr   = outAddrQ;
  assign memWrData = outDataQ;
  assign remaining = remainQ;
  assign outBusy   = outValidQ;

endmodule

// File: rtl/rxdma_control.sv
module rxdma_control
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              epValid,
  input  logic              epLast,
  input  logic              epShort,
  input  logic              epZlp,
  output logic              epReady,
  input  logic [LEN_W-1:0]  remaining,
  input  logic              outBusy,
  input  logic              canLoad,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] startAddr,
  output logic [LEN_W-1:0]  startLen,
  output logic              chActive,
  output logic              bufFlag,
  output logic              xfrFlag,
  output logic              irqBufEnd,
  output logic              irqXferEnd
);

  localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);

  chState_t          stateQ, stateD;
  logic [ADDR_W-1:0] bufAddrQ;
  logic [LEN_W-1:0]  bufLenQ;
  logic              truncEnQ, shortEnQ, bufIrqEnQ, xfrIrqEnQ;
  logic              pendBufQ, pendBufD, pendXfrQ, pendXfrD;
  logic              bufFlagQ, xfrFlagQ;
  logic              setBuf, setXfr;
  logic [REG_W-1:0]  rdMux, rdDataQ;

  logic ctrlWr, runReq, abortReq, accept, lastSlot, shortEnd, statRead;

  assign ctrlWr   = regWrEn && (regAddr == OFS_CTRL);
  assign runReq   = regWrData[CB_RUN];
  assign abortReq = ctrlWr && !runReq;
  assign statRead = regRdEn && (regAddr == OFS_STAT);

  assign epReady  = ((stateQ == ST_RUN) && canLoad) || (stateQ == ST_DISCARD);
  assign accept   = epValid && epReady;
  assign lastSlot = (remaining == ONE_LEFT);
  assign shortEnd = epLast && epShort && shortEnQ;

  always_comb begin
    stateD       = stateQ;
    pendBufD     = pendBufQ;
    pendXfrD     = pendXfrQ;
    setBuf       = 1'b0;
    setXfr       = 1'b0;
    strobe.load  = 1'b0;
    strobe.push  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (ctrlWr && runReq) begin
          strobe.load = 1'b1;
          pendXfrD    = 1'b0;
          if (bufLenQ == '0) begin
            pendBufD = 1'b1;
            stateD   = ST_DRAIN;
          end else begin
            pendBufD = 1'b0;
            stateD   = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (abortReq) begin
          stateD = ST_IDLE;
        end else if (accept) begin
          if (epZlp) begin
            if (shortEnQ) begin
              pendXfrD = 1'b1;
              stateD   = ST_DRAIN;
            end
          end else begin
            strobe.push = 1'b1;
            pendBufD    = lastSlot;
            pendXfrD    = shortEnd;
            if (lastSlot && !epLast && truncEnQ) begin
              stateD = ST_DISCARD;
            end else if (lastSlot || shortEnd) begin
              stateD = ST_DRAIN;
            end
          end
        end
      end
      ST_DISCARD: begin
        if (abortReq) begin
          stateD = ST_IDLE;
        end else if (accept && epLast) begin
          stateD = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (abortReq) begin
          stateD = ST_IDLE;
        end else if (!outBusy) begin
          setBuf = pendBufQ;
          setXfr = pendXfrQ;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      pendBufQ <= 1'b0;
      pendXfrQ <= 1'b0;
      bufFlagQ <= 1'b0;
      xfrFlagQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      pendBufQ <= pendBufD;
      pendXfrQ <= pendXfrD;
      bufFlagQ <= setBuf || (bufFlagQ && !statRead);
      xfrFlagQ <= setXfr || (xfrFlagQ && !statRead);
    end
  end

  // software-visible configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufAddrQ  <= '0;
      bufLenQ   <= '0;
      truncEnQ  <= 1'b0;
      shortEnQ  <= 1'b0;
      bufIrqEnQ <= 1'b0;
      xfrIrqEnQ <= 1'b0;
    end else if (regWrEn) begin
      case (regAddr)
        OFS_ADDR: bufAddrQ <= regWrData[ADDR_W-1:0];
        OFS_LEN:  bufLenQ  <= regWrData[LEN_W-1:0];
        OFS_CTRL: begin
          truncEnQ  <= regWrData[CB_TRUNC];
          shortEnQ  <= regWrData[CB_SHORT];
          bufIrqEnQ <= regWrData[CB_BUFIRQ];
          xfrIrqEnQ <= regWrData[CB_XFRIRQ];
        end
        default: ;
      endcase
    end
  end

  assign chActive = (stateQ != ST_IDLE);

  always_comb begin
    rdMux = '0;
    case (regAddr)
      OFS_ADDR: rdMux = REG_W'(bufAddrQ);
      OFS_LEN:  rdMux = REG_W'(bufLenQ);
      OFS_CTRL: begin
        rdMux[CB_RUN]    = chActive;
        rdMux[CB_TRUNC]  = truncEnQ;
        rdMux[CB_SHORT]  = shortEnQ;
        rdMux[CB_BUFIRQ] = bufIrqEnQ;
        rdMux[CB_XFRIRQ] = xfrIrqEnQ;
      end
      default: begin
        rdMux[SB_ACTIVE]               = chActive;
        rdMux[SB_BUFEND]               = bufFlagQ;
        rdMux[SB_XFREND]               = xfrFlagQ;
        rdMux[SB_CNT_LSB +: LEN_W]     = remaining;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        rdDataQ <= '0;
    else if (regRdEn) rdDataQ <= rdMux;
  end

  assign regRdData  = rdDataQ;
  assign startAddr  = bufAddrQ;
  assign startLen   = bufLenQ;
  assign bufFlag    = bufFlagQ;
  assign xfrFlag    = xfrFlagQ;
  assign irqBufEnd  = bufFlagQ && bufIrqEnQ;
  assign irqXferEnd = xfrFlagQ && xfrIrqEnQ;

endmodule

// File: rtl/rxdma_out_channel.sv
module rxdma_out_channel
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              epValid,
  output logic              epReady,
  input  logic [7:0]        epData,
  input  logic              epLast,
  input  logic              epShort,
  input  logic              epZlp,
  output logic              memWrEn,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic              irqBufEnd,
  output logic              irqXferEnd
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] startAddr;
  logic [LEN_W-1:0]  startLen;
  logic [LEN_W-1:0]  remaining;
  logic              outBusy, canLoad, chActive, bufFlag, xfrFlag;

  rxdma_control #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .epValid(epValid), .epLast(epLast), .epShort(epShort), .epZlp(epZlp),
    .epReady(epReady),
    .remaining(remaining), .outBusy(outBusy), .canLoad(canLoad),
    .strobe(strobe), .startAddr(startAddr), .startLen(startLen),
    .chActive(chActive), .bufFlag(bufFlag), .xfrFlag(xfrFlag),
    .irqBufEnd(irqBufEnd), .irqXferEnd(irqXferEnd)
  );

  rxdma_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uData (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .startAddr(startAddr), .startLen(startLen),
    .byteIn(epData), .memReady(memReady),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .remaining(remaining), .outBusy(outBusy), .canLoad(canLoad)
  );

endmodule

// File: rtl/rxdma_checker.sv
module rxdma_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              epReady,
  input logic              memWrEn,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memWrData,
  input logic              chActive,
  input logic [LEN_W-1:0]  remaining,
  input logic              bufFlag,
  input logic              xfrFlag
);

  // R10: a stalled write keeps address and data
  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !memReady) |=> (memWrEn && $stable(memAddr) && $stable(memWrData)));

  // R4: an idle channel never takes endpoint beats
  a_r4_idle_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    !chActive |-> !epReady);

  // R1: no new write starts while idle
  a_r1_no_write_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    !chActive |=> !$rose(memWrEn));

  // R3: while running the count holds or falls by exactly one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    chActive |=> (!chActive || remaining == $past(remaining)
                  || remaining == $past(remaining) - LEN_W'(1)));

  // R8: flags appear only once the final write is gone
  a_r8_bufflag_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFlag) |-> !memWrEn);

  a_r8_xfrflag_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xfrFlag) |-> !memWrEn);

endmodule

bind rxdma_out_channel rxdma_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uChk (
  .clk(clk), .rstN(rstN), .epReady(epReady), .memWrEn(memWrEn),
  .memReady(memReady), .memAddr(memAddr), .memWrData(memWrData),
  .chActive(chActive), .remaining(remaining), .bufFlag(bufFlag),
  .xfrFlag(xfrFlag)
);

// File: tb/tb_rxdma_out_channel.sv
`timescale 1ns/1ps
module tb_rxdma_out_channel;

  localparam int ADDR_W = 32;
  localparam logic [31:0] C_TRUNC = 32'h2, C_SHORT = 32'h4,
                          C_BUFIRQ = 32'h8, C_XFRIRQ = 32'h10;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [1:0] regAddr = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic epValid = 0, epReady, epLast = 0, epShort = 0, epZlp = 0;
  logic [7:0] epData = 0;
  logic memWrEn, memReady = 1;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memWrData;
  logic irqBufEnd, irqXferEnd;

  int nChecks = 0, nErrors = 0, wrCount = 0;
  logic [7:0] mem [256];

  always #5 clk = ~clk;

  rxdma_out_channel dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .epValid(epValid), .epReady(epReady), .epData(epData), .epLast(epLast),
    .epShort(epShort), .epZlp(epZlp), .memWrEn(memWrEn), .memReady(memReady),
    .memAddr(memAddr), .memWrData(memWrData),
    .irqBufEnd(irqBufEnd), .irqXferEnd(irqXferEnd)
  );

  always @(posedge clk)
    if (rstN && memWrEn && memReady) begin
      mem[memAddr[7:0]] <= memWrData;
      wrCount <= wrCount + 1;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1; regAddr = a;
    @(negedge clk); regRdEn = 0; d = regRdData;
  endtask

  task automatic startChan(input logic [31:0] a, input logic [31:0] len, input logic [31:0] ctl);
    regWrite(2'd0, a);
    regWrite(2'd1, len);
    regWrite(2'd2, ctl | 32'h1);
  endtask

  task automatic sendBeat(input logic [7:0] d, input logic last, input logic shrt, input logic zlp);
    @(negedge clk);
    epValid = 1; epData = d; epLast = last; epShort = shrt; epZlp = zlp;
    #1;
    while (!epReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    epValid = 0; epLast = 0; epShort = 0; epZlp = 0;
  endtask

  task automatic sendPkt(input logic [7:0] base, input int n, input logic shrt);
    for (int i = 0; i < n; i++)
      sendBeat(base + 8'(i), i == n - 1, shrt && (i == n - 1), 1'b0);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] s;
    @(negedge clk);
    chk("R1 memWrEn", {31'b0, memWrEn}, 0);
    chk("R1 epReady", {31'b0, epReady}, 0);
    chk("R1 irqs", {30'b0, irqBufEnd, irqXferEnd}, 0);
    regRead(2'd3, s);
    chk("R1 status", s, 0);
  endtask

  task automatic testBasic();
    logic [31:0] s; int w0;
    w0 = wrCount;
    startChan(32'h10, 8, C_BUFIRQ);
    sendPkt(8'h40, 4, 0);
    settle();
    regRead(2'd3, s);
    chk("R3 count after 4 bytes", s, 32'h0004_0001);
    sendPkt(8'h44, 4, 0);
    settle();
    chk("R8 irqBufEnd", {31'b0, irqBufEnd}, 1);
    chk("R2 write count", wrCount - w0, 8);
    for (int i = 0; i < 8; i++)
      chk("R2 memory byte", {24'b0, mem[8'h10 + 8'(i)]}, 32'h40 + i);
    regRead(2'd2, s);
    chk("R4 run bit cleared", s, C_BUFIRQ);
    regRead(2'd3, s);
    chk("R4 status buffer end", s, 32'h2);
    chk("R9 irq drops after read", {31'b0, irqBufEnd}, 0);
    regRead(2'd3, s);
    chk("R9 flags cleared", s, 0);
  endtask

  task automatic testNoTrunc();
    logic [31:0] s; int w0;
    w0 = wrCount;
    startChan(32'h30, 3, 0);
    for (int i = 0; i < 3; i++) sendBeat(8'h50 + 8'(i), 0, 0, 0);
    @(negedge clk); epValid = 1; epData = 8'h53;
    repeat (4) @(negedge clk);
    #1;
    chk("R4 leftover refused", {31'b0, epReady}, 0);
    epValid = 0;
    settle();
    chk("R4 write count", wrCount - w0, 3);
    regRead(2'd3, s);
    chk("R4 status", s, 32'h2);
  endtask

  task automatic testTrunc();
    logic [31:0] s; int w0;
    w0 = wrCount;
    startChan(32'h50, 3, C_TRUNC);
    sendPkt(8'h60, 6, 0);
    settle();
    chk("R5 only buffer bytes written", wrCount - w0, 3);
    chk("R5 last kept byte", {24'b0, mem[8'h52]}, 32'h62);
    chk("R8 irq masked", {31'b0, irqBufEnd}, 0);
    regRead(2'd3, s);
    chk("R5 status", s, 32'h2);
  endtask

  task automatic testShort();
    logic [31:0] s; int w0;
    w0 = wrCount;
    startChan(32'h70, 16, C_SHORT | C_XFRIRQ);
    sendPkt(8'h80, 5, 1);
    settle();
    chk("R6 irqXferEnd", {31'b0, irqXferEnd}, 1);
    chk("R6 write count", wrCount - w0, 5);
    regRead(2'd3, s);
    chk("R6 status short end", s, 32'h000B_0004);
    startChan(32'h90, 8, 0);
    sendPkt(8'hA0, 3, 1);
    settle();
    regRead(2'd3, s);
    chk("R6 short ignored when off", s, 32'h0005_0001);
    regWrite(2'd2, 0);
    settle();
    regRead(2'd3, s);
    chk("R11 abort", s, 32'h0005_0000);
    chk("R11 no irq", {30'b0, irqBufEnd, irqXferEnd}, 0);
  endtask

  task automatic testZlp();
    logic [31:0] s; int w0;
    w0 = wrCount;
    startChan(32'hB0, 8, C_SHORT);
    sendBeat(8'h00, 1, 1, 1);
    settle();
    regRead(2'd3, s);
    chk("R7 zlp ends transfer", s, 32'h0008_0004);
    chk("R7 zlp writes nothing", wrCount - w0, 0);
    startChan(32'hB0, 8, 0);
    sendBeat(8'h00, 1, 1, 1);
    settle();
    regRead(2'd3, s);
    chk("R7 zlp ignored when off", s, 32'h0008_0001);
    chk("R7 no write", wrCount - w0, 0);
    regWrite(2'd2, 0);
    settle();
  endtask

  task automatic testStall();
    logic [31:0] s; int w0;
    w0 = wrCount;
    startChan(32'hC0, 4, 0);
    @(negedge clk); memReady = 0;
    sendBeat(8'hD0, 0, 0, 0);
    @(negedge clk); epValid = 1; epData = 8'hD1;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 write held", {31'b0, memWrEn}, 1);
    chk("R10 addr held", memAddr, 32'hC0);
    chk("R10 data held", {24'b0, memWrData}, 32'hD0);
    chk("R10 epReady low", {31'b0, epReady}, 0);
    chk("R10 no write during stall", wrCount - w0, 0);
    epValid = 0;
    memReady = 1;
    sendBeat(8'hD1, 0, 0, 0);
    sendBeat(8'hD2, 0, 0, 0);
    sendBeat(8'hD3, 1, 0, 0);
    settle();
    for (int i = 0; i < 4; i++)
      chk("R10 R2 memory after stall", {24'b0, mem[8'hC0 + 8'(i)]}, 32'hD0 + i);
    regRead(2'd3, s);
    chk("R10 status", s, 32'h2);
  endtask

  task automatic testZero();
    logic [31:0] s; int w0;
    w0 = wrCount;
    startChan(32'hE0, 0, C_BUFIRQ);
    settle();
    chk("R12 irqBufEnd", {31'b0, irqBufEnd}, 1);
    chk("R12 no write", wrCount - w0, 0);
    regRead(2'd3, s);
    chk("R12 status", s, 32'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    testReset();
    testBasic();
    testNoTrunc();
    testTrunc();
    testShort();
    testZlp();
    testStall();
    testZero();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule